// File: doc/BRIEF.md
# Run-Time Configurable AND-OR Logic Array

This block is a combinational sum-of-products engine whose connections are held in registers. Both planes can be set at run time. Each product term can pick up any input, the inverse of any input, or both. Each output can gather any set of product terms. Each output also has an inversion bit, so it gives either the OR of its terms or the inverted form of that OR.

The input count, the product-term count and the output count are parameters. The default build has three inputs, three terms and two outputs. A build with four inputs, nine terms and four outputs holds a BCD-to-Excess-3 converter.

A word-addressed configuration port writes the masks. A select field picks the target of the write: an AND row, an OR row or the polarity word. An index field picks the row. A write takes effect on the next rising clock edge. Between edges, the output follows the input through pure gates.

Top module: `lpa_array`

## Requirements
- R1: Each product term is the AND of the literals its row enables. A term whose row enables no literal is 1.
- R2: A product term that enables both the true and the inverted literal of one input is 0 for every input value.
- R3: Each output's sum is the OR of the product terms enabled in that output's OR row. An OR row that enables no term gives a sum of 0.
- R4: With polarity bit j at 1, output j is the inverse of its sum. With the bit at 0, output j equals its sum.
- R5: When cfg_we is 1 at a rising edge, the write target depends on cfg_sel. With cfg_sel=0, term cfg_idx takes true mask cfg_data[N_IN-1:0] and inverted mask cfg_data[2*N_IN-1:N_IN]. With cfg_sel=1, output row cfg_idx takes term mask cfg_data[N_TERM-1:0]. With cfg_sel=2, the polarity word takes cfg_data[N_OUT-1:0]. In mask bit positions, bit i means input i or term i. Until that edge, fn_out is computed from the old settings.
- R6: A write has no effect on any setting in three cases: cfg_sel=3, an index beyond the last row of the selected plane, or cfg_we at 0.
- R7: While rst_n is low, all masks and polarity bits are cleared, so every output reads 0 for every input.
- R8: With N_IN=4, N_TERM=9 and N_OUT=4, the array can be set so that fn_out equals lit_in+3 for inputs 0 through 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 AND row, 1 OR row, 2 polarity, 3 none |
| cfg_idx | input | IW | Row index for AND or OR writes |
| cfg_data | input | DW | Write data word |
| lit_in | input | N_IN | Logic inputs |
| fn_out | output | N_OUT | Logic outputs |

## Verification
A configuration write and a live evaluation can fall in the same cycle. The bench provokes this by driving a new input value and a write strobe at the same falling edge. Just before the next rising edge, fn_out must still match the old settings. Just after that edge, fn_out must match the new ones. Each value is judged against a model that the bench builds from its own shadow copy of the writes.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

   typedef enum logic [1:0] {
      SEL_AND  = 2'd0,
      SEL_OR   = 2'd1,
      SEL_POL  = 2'd2,
      SEL_NONE = 2'd3
   } cfg_sel_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lpa_cfg_regs.sv
module lpa_cfg_regs import lpa_pkg::*; #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 3,
   parameter int N_OUT  = 2,
   parameter int IW     = 2,
   parameter int DW     = 6,
   parameter bit POL_EN = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [1:0]                     sel,
   input  logic [IW-1:0]                  idx,
   input  logic [DW-1:0]                  data,
   output logic [N_TERM-1:0][N_IN-1:0]    and_true,
   output logic [N_TERM-1:0][N_IN-1:0]    and_comp,
   output logic [N_OUT-1:0][N_TERM-1:0]   or_mask,
   output logic [N_OUT-1:0]               pol
);

   logic hit_and, hit_or, hit_pol;

   always_comb begin
      hit_and = we && (sel == SEL_AND);
      hit_or  = we && (sel == SEL_OR);
      hit_pol = we && (sel == SEL_POL);
   end

   for (genvar t = 0; t < N_TERM; t++) begin : g_and_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            and_true[t] <= '0;
            and_comp[t] <= '0;
         end else if (hit_and && idx == IW'(t)) begin
            and_true[t] <= data[N_IN-1:0];
            and_comp[t] <= data[2*N_IN-1:N_IN];
         end
      end
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_or_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            or_mask[j] <= '0;
         else if (hit_or && idx == IW'(j))
            or_mask[j] <= data[N_TERM-1:0];
      end
   end

   if (POL_EN) begin : g_pol_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pol <= '0;
         else if (hit_pol)
            pol <= data[N_OUT-1:0];
      end
   end else begin : g_pol_fixed
      logic unused_pol;
      assign unused_pol = hit_pol;
      assign pol = '0;
   end

endmodule

// File: rtl/lpa_and_plane.sv
module lpa_and_plane #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 3
) (
   input  logic [N_IN-1:0]                lit_in,
   input  logic [N_TERM-1:0][N_IN-1:0]    and_true,
   input  logic [N_TERM-1:0][N_IN-1:0]    and_comp,
   output logic [N_TERM-1:0]              prod
);

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_IN-1:0] pass_t, pass_c;
      always_comb begin
         pass_t  = lit_in | ~and_true[t];
         pass_c  = ~lit_in | ~and_comp[t];
         prod[t] = &(pass_t & pass_c);
      end
   end

endmodule

// File: rtl/lpa_or_plane.sv
module lpa_or_plane #(
   parameter int N_TERM = 3,
   parameter int N_OUT  = 2
) (
   input  logic [N_TERM-1:0]              prod,
   input  logic [N_OUT-1:0][N_TERM-1:0]   or_mask,
   input  logic [N_OUT-1:0]               pol,
   output logic [N_OUT-1:0]               fn_out
);

   for (genvar j = 0; j < N_OUT; j++) begin : g_sum
      logic sum_j;
      always_comb begin
         sum_j     = |(prod & or_mask[j]);
         fn_out[j] = sum_j ^ pol[j];
      end
   end

endmodule

// File: rtl/lpa_array.sv
module lpa_array import lpa_pkg::*; #(
   parameter int  N_IN   = 3,
   parameter int  N_TERM = 3,
   parameter int  N_OUT  = 2,
   parameter bit  POL_EN = 1'b1,
   localparam int IW     = idx_bits((N_TERM > N_OUT) ? N_TERM : N_OUT),
   localparam int DW     = max3(2 * N_IN, N_TERM, N_OUT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [IW-1:0]     cfg_idx,
   input  logic [DW-1:0]     cfg_data,
   input  logic [N_IN-1:0]   lit_in,
   output logic [N_OUT-1:0]  fn_out
);

   if (N_IN < 1)   begin : g_bad_in   $error("lpa_array: N_IN must be at least 1");   end
   if (N_TERM < 1) begin : g_bad_term $error("lpa_array: N_TERM must be at least 1"); end
   if (N_OUT < 1)  begin : g_bad_out  $error("lpa_array: N_OUT must be at least 1");  end

   logic [N_TERM-1:0][N_IN-1:0]  and_true;
   logic [N_TERM-1:0][N_IN-1:0]  and_comp;
   logic [N_OUT-1:0][N_TERM-1:0] or_mask;
   logic [N_OUT-1:0]             pol;
   logic [N_TERM-1:0]            prod;

   lpa_cfg_regs #(
      .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
      .IW(IW), .DW(DW), .POL_EN(POL_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .idx(cfg_idx), .data(cfg_data),
      .and_true(and_true), .and_comp(and_comp),
      .or_mask(or_mask), .pol(pol)
   );

   lpa_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .lit_in(lit_in), .and_true(and_true), .and_comp(and_comp), .prod(prod)
   );

   lpa_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
      .prod(prod), .or_mask(or_mask), .pol(pol), .fn_out(fn_out)
   );

endmodule

// File: rtl/lpa_array_chk.sv
module lpa_array_chk #(
   parameter int N_IN   = 3,
   parameter int N_TERM = 3,
   parameter int N_OUT  = 2,
   parameter int IW     = 2,
   parameter int DW     = 6
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_we,
   input logic [1:0]                    cfg_sel,
   input logic [IW-1:0]                 cfg_idx,
   input logic [DW-1:0]                 cfg_data,
   input logic [N_OUT-1:0]              fn_out,
   input logic [N_TERM-1:0][N_IN-1:0]   and_true,
   input logic [N_TERM-1:0][N_IN-1:0]   and_comp,
   input logic [N_OUT-1:0][N_TERM-1:0]  or_mask,
   input logic [N_OUT-1:0]              pol,
   input logic [N_TERM-1:0]             prod
);

   // R7: the first edge after reset release sees cleared settings and zero outputs
   a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (and_true == '0 && and_comp == '0 && or_mask == '0 &&
                        pol == '0 && fn_out == '0));

   // R6: with no strobe, no setting moves
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(and_true) && $stable(and_comp) &&
                   $stable(or_mask) && $stable(pol)));

   for (genvar t = 0; t < N_TERM; t++) begin : g_chk_term
      // R5: an AND-row write lands on the addressed term
      a_r5_and_write: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_sel == 2'd0 && cfg_idx == IW'(t)) |=>
            (and_true[t] == $past(cfg_data[N_IN-1:0]) &&
             and_comp[t] == $past(cfg_data[2*N_IN-1:N_IN])));
      // R2: both literals of one input force the term low
      a_r2_contradiction: assert property (@(posedge clk) disable iff (!rst_n)
         ((and_true[t] & and_comp[t]) != '0) |-> !prod[t]);
      // R1: an empty row gives a true term
      a_r1_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
         (and_true[t] == '0 && and_comp[t] == '0) |-> prod[t]);
   end

   for (genvar j = 0; j < N_OUT; j++) begin : g_chk_out
      // R5: an OR-row write lands on the addressed output
      a_r5_or_write: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_sel == 2'd1 && cfg_idx == IW'(j)) |=>
            (or_mask[j] == $past(cfg_data[N_TERM-1:0])));
      // R3 R4: an empty OR row leaves only the polarity bit on the pin
      a_r3_empty_sum: assert property (@(posedge clk) disable iff (!rst_n)
         (or_mask[j] == '0) |-> (fn_out[j] == pol[j]));
   end

endmodule

bind lpa_array lpa_array_chk #(
   .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .IW(IW), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
   .cfg_idx(cfg_idx), .cfg_data(cfg_data), .fn_out(fn_out),
   .and_true(and_true), .and_comp(and_comp), .or_mask(or_mask),
   .pol(pol), .prod(prod)
);

// File: tb/lpa_array_tb.sv
module lpa_array_tb;

   localparam int NI = 3, NK = 3, NM = 2, IW = 2, DW = 6;
   localparam int BI = 4, BK = 9, BM = 4, BIW = 4, BDW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_sel = '0;
   logic [IW-1:0]   cfg_idx = '0;
   logic [DW-1:0]   cfg_data = '0;
   logic [NI-1:0]   lit_in = '0;
   logic [NM-1:0]   fn_out;

   logic            b_we = 1'b0;
   logic [1:0]      b_sel = '0;
   logic [BIW-1:0]  b_idx = '0;
   logic [BDW-1:0]  b_data = '0;
   logic [BI-1:0]   b_in = '0;
   logic [BM-1:0]   b_out;

   lpa_array #(.N_IN(NI), .N_TERM(NK), .N_OUT(NM)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data), .lit_in(lit_in), .fn_out(fn_out)
   );

   lpa_array #(.N_IN(BI), .N_TERM(BK), .N_OUT(BM)) u_bcd (
      .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_sel(b_sel),
      .cfg_idx(b_idx), .cfg_data(b_data), .lit_in(b_in), .fn_out(b_out)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [NI-1:0] sh_t [NK];
   logic [NI-1:0] sh_c [NK];
   logic [NK-1:0] sh_o [NM];
   logic [NM-1:0] sh_p;

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NM-1:0] model(input logic [NI-1:0] x);
      logic [NK-1:0] p;
      logic [NM-1:0] r;
      for (int t = 0; t < NK; t++)
         p[t] = ((x & sh_t[t]) == sh_t[t]) && ((~x & sh_c[t]) == sh_c[t]);
      for (int j = 0; j < NM; j++)
         r[j] = (|(p & sh_o[j])) ^ sh_p[j];
      return r;
   endfunction

   task automatic shadow(input logic [1:0] s, input logic [IW-1:0] i, input logic [DW-1:0] d);
      if (s == 2'd0 && i < NK) begin
         sh_t[i] = d[NI-1:0];
         sh_c[i] = d[2*NI-1:NI];
      end else if (s == 2'd1 && i < NM) begin
         sh_o[i] = d[NK-1:0];
      end else if (s == 2'd2) begin
         sh_p = d[NM-1:0];
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [IW-1:0] i, input logic [DW-1:0] d,
                     input bit we);
      @(negedge clk);
      cfg_we = we; cfg_sel = s; cfg_idx = i; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (we) shadow(s, i, d);
   endtask

   task automatic sweep(input string tag);
      for (int x = 0; x < (1 << NI); x++) begin
         lit_in = NI'(x);
         #1;
         chk(tag, 9'(fn_out), 9'(model(NI'(x))));
      end
   endtask

   task automatic bwr(input logic [1:0] s, input logic [BIW-1:0] i, input logic [BDW-1:0] d);
      @(negedge clk);
      b_we = 1'b1; b_sel = s; b_idx = i; b_data = d;
      @(negedge clk);
      b_we = 1'b0;
   endtask

   initial begin
      for (int t = 0; t < NK; t++) begin sh_t[t] = '0; sh_c[t] = '0; end
      for (int j = 0; j < NM; j++) sh_o[j] = '0;
      sh_p = '0;

      repeat (3) @(negedge clk);
      // R7: outputs are zero while held in reset and just after release
      for (int x = 0; x < (1 << NI); x++) begin
         lit_in = NI'(x); #1;
         chk("R7 reset", 9'(fn_out), 9'h0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      sweep("R7 after release");

      // R1: empty term 0 routed to output 0 gives a constant 1
      wr(2'd1, 2'd0, 6'b000001, 1'b1);
      for (int x = 0; x < (1 << NI); x++) begin
         lit_in = NI'(x); #1;
         chk("R1 empty term", 9'(fn_out[0]), 9'h1);
      end
      // R4: inverting output 1 with an empty OR row gives constant 1
      wr(2'd2, 2'd0, 6'b000010, 1'b1);
      for (int x = 0; x < (1 << NI); x++) begin
         lit_in = NI'(x); #1;
         chk("R4 inverted empty sum", 9'(fn_out[1]), 9'h1);
      end
      // R2: term 0 takes both literals of input 1
      wr(2'd0, 2'd0, 6'b010_010, 1'b1);
      wr(2'd2, 2'd0, 6'b000000, 1'b1);
      for (int x = 0; x < (1 << NI); x++) begin
         lit_in = NI'(x); #1;
         chk("R2 contradiction", 9'(fn_out[0]), 9'h0);
      end

      // R1 R3 R4 R5: sweeps over many settings
      for (int it = 0; it < 40; it++) begin
         for (int t = 0; t < NK; t++) wr(2'd0, IW'(t), DW'($urandom), 1'b1);
         for (int j = 0; j < NM; j++) wr(2'd1, IW'(j), DW'($urandom), 1'b1);
         wr(2'd2, 2'd0, DW'($urandom), 1'b1);
         sweep("R1 R3 R4 R5 sweep");
      end

      // R5: write and new input in one cycle; old settings until the edge
      for (int k = 0; k < 6; k++) begin
         logic [NM-1:0] before_v;
         @(negedge clk);
         lit_in = NI'(k + 1);
         cfg_we = 1'b1; cfg_sel = 2'd2; cfg_idx = '0; cfg_data = DW'(~sh_p);
         #1;
         before_v = model(NI'(k + 1));
         chk("R5 before edge", 9'(fn_out), 9'(before_v));
         @(posedge clk);
         shadow(2'd2, '0, DW'(~sh_p));
         #1;
         chk("R5 after edge", 9'(fn_out), 9'(model(NI'(k + 1))));
         @(negedge clk);
         cfg_we = 1'b0;
      end

      // R6: ignored writes leave every output as it was
      wr(2'd3, 2'd0, 6'b111111, 1'b1);
      sweep("R6 select 3");
      wr(2'd0, 2'd3, 6'b101010, 1'b1);
      sweep("R6 AND index out of range");
      wr(2'd1, 2'd2, 6'b111111, 1'b1);
      sweep("R6 OR index out of range");
      wr(2'd2, 2'd0, DW'(~sh_p), 1'b0);
      sweep("R6 strobe low");

      // R8: BCD to Excess-3; in[3]=A in[2]=B in[1]=C in[0]=D
      bwr(2'd0, 4'd0, 9'h008);
      bwr(2'd0, 4'd1, 9'h006);
      bwr(2'd0, 4'd2, 9'h005);
      bwr(2'd0, 4'd3, 9'h034);
      bwr(2'd0, 4'd4, 9'h042);
      bwr(2'd0, 4'd5, 9'h041);
      bwr(2'd0, 4'd6, 9'h030);
      bwr(2'd0, 4'd7, 9'h003);
      bwr(2'd0, 4'd8, 9'h010);
      bwr(2'd1, 4'd3, 9'h007);
      bwr(2'd1, 4'd2, 9'h038);
      bwr(2'd1, 4'd1, 9'h0C0);
      bwr(2'd1, 4'd0, 9'h100);
      for (int d = 0; d < 10; d++) begin
         b_in = BI'(d); #1;
         chk("R8 excess-3", 9'(b_out), 9'(d + 3));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule